// File: doc/BRIEF.md
# Page-Mode Memory Read Sequencer

This block turns single read requests from inside the chip into read cycles on an external asynchronous memory that supports page mode, such as a burst ROM or a page-mode flash. It remembers which page it opened last: the page is defined by the selected chip and by every address bit above the in-page offset. Each new request is compared against that page. A miss, or the first read after the page was closed, holds the strobes for the programmable long access time. A hit holds them only for the short access time. The hit may land on any offset in the page, in any order.

The page closes on reset, on any change of the page-size or timing settings, and when the shared bus reports that some other target was accessed in between. The two timings are applied as programmed, with no check that they make sense. The memory's wait input is ignored, because page mode and wait stretching do not go together.

The controller is a four-state machine. `ST_IDLE` waits for a request. On acceptance it takes the transition *miss* to `ST_FIRST` or the transition *hit* to `ST_INPAGE`. Either access state takes *count_done* to `ST_RESP` when its strobe count runs out, and `ST_RESP` always takes *return* back to `ST_IDLE`.

Top module: `pm_read_seq`

## Requirements
- R1: `req_ready` is 1 only in the idle state. An accepted request (`req_valid` and `req_ready` high at a clock edge) drives `mem_rd_n` low from the very next cycle. `req_ready` stays 0 while the strobe is active.
- R2: A read that is not a page hit holds `mem_rd_n` and its chip select low for exactly `cfg_long_len` cycles. A programmed value of 0 counts as 1.
- R3: A page hit holds `mem_rd_n` and its chip select low for exactly `cfg_short_len` cycles. A programmed value of 0 counts as 1.
- R4: A read is a hit only when the page is open, its `req_cs` equals that of the previous read, and its address bits above the page offset equal those of the previous read. The offset may take any value, not only the next one in sequence.
- R5: A change of `req_cs`, or of any address bit above the page offset, makes the read a miss.
- R6: A one-cycle pulse on `ext_other_txn` while the block is idle closes the page, so the next read is a miss.
- R7: The timings are not checked for coherence. When `cfg_short_len` is larger than `cfg_long_len`, hits still use `cfg_short_len` and misses still use `cfg_long_len`.
- R8: `cfg_page_sel` values 0, 1, 2 and 3 select pages of 4, 8, 16 and 32 bytes. The page offset is therefore the low 2, 3, 4 or 5 address bits.
- R9: While the strobe is active, `mem_be_n` equals the bitwise inverse of the accepted `req_be`. At all other times it is all ones.
- R10: `mem_wait` has no effect on strobe length or data.
- R11: Reset closes the page. So does any change of `cfg_page_sel`, `cfg_long_len` or `cfg_short_len` while idle. The next read is a miss.
- R12: `rsp_valid` is a one-cycle pulse in the cycle after the last strobe cycle. `rsp_data` then holds the `mem_rdata` value sampled in that last strobe cycle, which is the data for the accepted address driven on `mem_addr`.
- R13: During a strobe, exactly one bit of `mem_cs_n` is low: bit `req_cs` of the accepted request. In every other cycle all bits of `mem_cs_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_page_sel | input | 2 | Page size: 0=4 B, 1=8 B, 2=16 B, 3=32 B |
| cfg_long_len | input | CNT_W | Strobe length in cycles for a first access to a page |
| cfg_short_len | input | CNT_W | Strobe length in cycles for an in-page access |
| ext_other_txn | input | 1 | Pulse: another target used the external bus |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Byte address of the read |
| req_cs | input | CS_W | Index of the chip select to use |
| req_be | input | BE_W | Byte enables, active high |
| mem_cs_n | output | NUM_CS | Chip selects, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_addr | output | ADDR_W | Address driven to the memory |
| mem_be_n | output | BE_W | Byte selects, active low |
| mem_wait | input | 1 | Memory wait request, ignored |
| mem_rdata | input | DATA_W | Data returned by the memory |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_data | output | DATA_W | Read data |

## Verification
The assertions assume that `ext_other_txn` pulses never overlap one of the block's own accesses, because a shared bus cannot carry two transfers at once. They also assume that the configuration inputs do not change in the cycle a request is accepted. The stimulus enforces both assumptions: it pulses `ext_other_txn` and rewrites the configuration only from the idle state, and it waits a full cycle before issuing the next request. Random addresses are drawn from a few nearby page bases with random offsets and two chip selects, so hits, upper-bit misses and chip-select misses all occur often. `mem_wait` toggles freely throughout the run.

// File: rtl/pm_pkg.sv
package pm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FIRST,
        ST_INPAGE,
        ST_RESP
    } pm_state_e;
endpackage

// File: rtl/pm_page_track.sv
module pm_page_track #(
    parameter int ADDR_W  = 24,
    parameter int CS_W    = 2,
    parameter int SEL_W   = 2,
    parameter int CNT_W   = 6,
    parameter int MIN_OFF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [CNT_W-1:0]  cfg_long,
    input  logic [CNT_W-1:0]  cfg_short,
    input  logic              other_txn,
    input  logic              open_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CS_W-1:0]   cs,
    output logic              hit
);
    localparam int CFG_W = SEL_W + 2 * CNT_W;

    logic [CFG_W-1:0]  cfg_now;
    logic [CFG_W-1:0]  cfg_q;
    logic              cfg_chg;
    logic              page_vld;
    logic [CS_W-1:0]   page_cs;
    logic [ADDR_W-1:0] page_addr;
    logic [ADDR_W-1:0] upper_mask;

    assign cfg_now    = {cfg_sel, cfg_long, cfg_short};
    assign cfg_chg    = (cfg_now != cfg_q);
    assign upper_mask = {ADDR_W{1'b1}} << (MIN_OFF + int'(cfg_sel));

    // A hit needs an open page, the same chip and the same upper address bits.
    assign hit = page_vld && !cfg_chg && !other_txn && (cs == page_cs)
                 && ((addr & upper_mask) == (page_addr & upper_mask));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            page_vld  <= 1'b0;
            page_cs   <= '0;
            page_addr <= '0;
        end else begin
            cfg_q <= cfg_now;
            if (open_en) begin
                page_vld  <= 1'b1;
                page_cs   <= cs;
                page_addr <= addr;
            end else if (cfg_chg || other_txn) begin
                page_vld <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pm_strobe_timer.sv
module pm_strobe_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    input  logic             run,
    output logic             last
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] len_eff;

    // A programmed length of zero still gives one strobe cycle.
    assign len_eff = (len == '0) ? CNT_W'(1) : len;
    assign last    = (cnt <= CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= len_eff;
        end else if (run && !last) begin
            cnt <= cnt - CNT_W'(1);
        end
    end
endmodule

// File: rtl/pm_read_seq.sv
module pm_read_seq #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32,
    parameter int NUM_CS = 4,
    parameter int CNT_W  = 6,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_page_sel,
    input  logic [CNT_W-1:0]  cfg_long_len,
    input  logic [CNT_W-1:0]  cfg_short_len,
    input  logic              ext_other_txn,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CS_W-1:0]   req_cs,
    input  logic [BE_W-1:0]   req_be,
    output logic [NUM_CS-1:0] mem_cs_n,
    output logic              mem_rd_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BE_W-1:0]   mem_be_n,
    input  logic              mem_wait,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    import pm_pkg::*;

    pm_state_e         state, state_nx;
    logic              accept;
    logic              hit;
    logic              strobe;
    logic              last;
    logic [CNT_W-1:0]  sel_len;
    logic [ADDR_W-1:0] addr_q;
    logic [CS_W-1:0]   cs_q;
    logic [BE_W-1:0]   be_q;
    logic [DATA_W-1:0] data_q;
    logic              unused_wait;

    // Page mode excludes wait stretching: the wait input is dropped.
    assign unused_wait = mem_wait;

    assign accept  = req_valid && (state == ST_IDLE);
    assign sel_len = hit ? cfg_short_len : cfg_long_len;

    pm_page_track #(
        .ADDR_W (ADDR_W),
        .CS_W   (CS_W),
        .SEL_W  (2),
        .CNT_W  (CNT_W),
        .MIN_OFF(2)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_sel  (cfg_page_sel),
        .cfg_long (cfg_long_len),
        .cfg_short(cfg_short_len),
        .other_txn(ext_other_txn),
        .open_en  (accept),
        .addr     (req_addr),
        .cs       (req_cs),
        .hit      (hit)
    );

    pm_strobe_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .load (accept),
        .len  (sel_len),
        .run  (strobe),
        .last (last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (req_valid) state_nx = hit ? ST_INPAGE : ST_FIRST;
            ST_FIRST:  if (last) state_nx = ST_RESP;
            ST_INPAGE: if (last) state_nx = ST_RESP;
            ST_RESP:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Request capture and read data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            cs_q   <= '0;
            be_q   <= '0;
            data_q <= '0;
        end else begin
            if (accept) begin
                addr_q <= req_addr;
                cs_q   <= req_cs;
                be_q   <= req_be;
            end
            if (strobe && last) begin
                data_q <= mem_rdata;
            end
        end
    end

    // Outputs
    always_comb begin
        strobe    = 1'b0;
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        unique case (state)
            ST_IDLE:   req_ready = 1'b1;
            ST_FIRST:  strobe    = 1'b1;
            ST_INPAGE: strobe    = 1'b1;
            ST_RESP:   rsp_valid = 1'b1;
            default:   strobe    = 1'b0;
        endcase
        mem_rd_n = !strobe;
        mem_cs_n = '1;
        mem_be_n = '1;
        if (strobe) begin
            mem_cs_n[cs_q] = 1'b0;
            mem_be_n       = ~be_q;
        end
    end

    assign mem_addr = addr_q;
    assign rsp_data = data_q;
endmodule

// File: rtl/pm_read_seq_chk.sv
module pm_read_seq_chk #(
    parameter int NUM_CS = 4,
    parameter int BE_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [NUM_CS-1:0] mem_cs_n,
    input logic              mem_rd_n,
    input logic [BE_W-1:0]   mem_be_n,
    input logic              rsp_valid
);
    AST_ACCEPT_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !mem_rd_n); // R1
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_n |-> !req_ready); // R1
    AST_BYTESEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_n |-> (&mem_be_n)); // R9
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R12
    AST_RSP_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (mem_rd_n && $past(!mem_rd_n))); // R12
    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n)); // R13
    AST_CS_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~mem_cs_n) == (mem_rd_n ? 0 : 1)); // R13
endmodule

bind pm_read_seq pm_read_seq_chk #(
    .NUM_CS(NUM_CS),
    .BE_W  (BE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .mem_cs_n (mem_cs_n),
    .mem_rd_n (mem_rd_n),
    .mem_be_n (mem_be_n),
    .rsp_valid(rsp_valid)
);

// File: tb/pm_read_seq_bench.sv
`timescale 1ns/1ps
module pm_read_seq_bench;
    localparam int ADDR_W = 24;
    localparam int DATA_W = 32;
    localparam int NUM_CS = 4;
    localparam int CNT_W  = 6;
    localparam int CS_W   = 2;
    localparam int BE_W   = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        cfg_page_sel = 2'd1;
    logic [CNT_W-1:0]  cfg_long_len = 6'd6;
    logic [CNT_W-1:0]  cfg_short_len = 6'd2;
    logic              ext_other_txn = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [CS_W-1:0]   req_cs = '0;
    logic [BE_W-1:0]   req_be = '0;
    logic [NUM_CS-1:0] mem_cs_n;
    logic              mem_rd_n;
    logic [ADDR_W-1:0] mem_addr;
    logic [BE_W-1:0]   mem_be_n;
    logic              mem_wait = 1'b0;
    logic [DATA_W-1:0] mem_rdata;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_data;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;
    bit  wait_rand = 1'b1;

    // Bench page model
    bit              m_vld = 1'b0;
    int              m_cs = 0;
    logic [ADDR_W-1:0] m_addr = '0;

    always #2.5 clk = ~clk;

    function automatic logic [DATA_W-1:0] data_of(logic [ADDR_W-1:0] a);
        return {8'hC3, a} ^ 32'h5A5A_0F0F;
    endfunction

    assign mem_rdata = data_of(mem_addr);

    pm_read_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CS(NUM_CS), .CNT_W(CNT_W)
    ) u_pm_read_seq (
        .clk(clk), .rst_n(rst_n), .cfg_page_sel(cfg_page_sel),
        .cfg_long_len(cfg_long_len), .cfg_short_len(cfg_short_len),
        .ext_other_txn(ext_other_txn), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .req_cs(req_cs),
        .req_be(req_be), .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n),
        .mem_addr(mem_addr), .mem_be_n(mem_be_n), .mem_wait(mem_wait),
        .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    task automatic check(input bit ok, input string req, input longint act,
                         input longint exp, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit m_hit(logic [ADDR_W-1:0] a, int c);
        int off = 2 + int'(cfg_page_sel);
        return m_vld && (c == m_cs) && ((a >> off) == (m_addr >> off));
    endfunction

    function automatic int eff(logic [CNT_W-1:0] v);
        return (v == 0) ? 1 : int'(v);
    endfunction

    // Change configuration from idle; any change closes the page (R11)
    task automatic set_cfg(input logic [1:0] sel, input logic [CNT_W-1:0] lg,
                           input logic [CNT_W-1:0] sh);
        @(negedge clk);
        if (sel != cfg_page_sel || lg != cfg_long_len || sh != cfg_short_len)
            m_vld = 1'b0;
        cfg_page_sel  = sel;
        cfg_long_len  = lg;
        cfg_short_len = sh;
        @(negedge clk);
    endtask

    task automatic pulse_other();
        @(negedge clk);
        ext_other_txn = 1'b1;
        @(negedge clk);
        ext_other_txn = 1'b0;
        m_vld = 1'b0;
    endtask

    // Issue one read and check strobe length, selects, data
    task automatic do_read(input logic [ADDR_W-1:0] a, input int c,
                           input logic [BE_W-1:0] be, input string tag);
        bit hit_e;
        int exp_len;
        int n = 0;
        int guard = 0;
        bit bad_cs = 1'b0;
        bit bad_be = 1'b0;
        bit bad_rdy = 1'b0;
        logic [NUM_CS-1:0] exp_cs_n;
        hit_e    = m_hit(a, c);
        exp_len  = hit_e ? eff(cfg_short_len) : eff(cfg_long_len);
        exp_cs_n = ~(NUM_CS'(1) << c);
        @(negedge clk);
        check(req_ready == 1'b1, "R1", req_ready, 1, "ready when idle");
        req_addr  = a;
        req_cs    = CS_W'(c);
        req_be    = be;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(mem_rd_n == 1'b0, "R1", mem_rd_n, 0, "strobe after accept");
        while (!rsp_valid && guard < 200) begin
            if (!mem_rd_n) begin
                n++;
                if (mem_cs_n != exp_cs_n) bad_cs = 1'b1;
                if (mem_be_n != ~be) bad_be = 1'b1;
                if (req_ready) bad_rdy = 1'b1;
            end
            @(negedge clk);
            guard++;
        end
        check(n == exp_len, tag, n, exp_len,
              hit_e ? "in-page strobe length R3" : "first strobe length R2");
        check(!bad_cs, "R13", bad_cs, 0, "chip select during strobe");
        check(!bad_be, "R9", bad_be, 0, "byte selects during strobe");
        check(!bad_rdy, "R1", bad_rdy, 0, "ready low while busy");
        check(rsp_valid == 1'b1, "R12", rsp_valid, 1, "response pulse");
        check(rsp_data == data_of(a), "R12", rsp_data, data_of(a), "read data");
        check(mem_addr == a, "R12", mem_addr, a, "memory address");
        check(mem_rd_n && (&mem_be_n) && (&mem_cs_n), "R9", mem_be_n, 4'hF,
              "selects released after strobe");
        m_vld  = 1'b1;
        m_cs   = c;
        m_addr = a;
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (wait_rand) mem_wait = 1'($urandom);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(mem_rd_n && (&mem_cs_n) && !rsp_valid, "R13", mem_cs_n, 4'hF,
              "outputs idle in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1", req_ready, 1, "ready after reset");

        // Directed: 8-byte page, long 6, short 2
        do_read(24'h000100, 0, 4'hF, "R11");   // first after reset: long
        do_read(24'h000103, 0, 4'h1, "R4");    // hit
        do_read(24'h000107, 0, 4'h2, "R4");    // non-sequential hit
        do_read(24'h000102, 0, 4'h3, "R4");    // backwards still hit
        do_read(24'h000108, 0, 4'hF, "R5");    // upper bits changed
        do_read(24'h00010C, 1, 4'hC, "R5");    // chip select changed
        do_read(24'h00010D, 1, 4'h4, "R3");    // hit on cs1
        do_read(24'h000108, 0, 4'hF, "R5");    // back to cs0: miss
        pulse_other();
        do_read(24'h000109, 0, 4'hF, "R6");    // other target closed page
        // Incoherent timings: short > long
        set_cfg(2'd1, 6'd2, 6'd7);
        do_read(24'h000109, 0, 4'hF, "R7");    // config change closed page: 2
        do_read(24'h00010A, 0, 4'hF, "R7");    // hit: 7
        // 32-byte page
        set_cfg(2'd3, 6'd5, 6'd1);
        do_read(24'h000200, 2, 4'hF, "R8");
        do_read(24'h00021F, 2, 4'h8, "R8");    // last byte of page: hit
        do_read(24'h000220, 2, 4'hF, "R8");    // next page: miss
        // 4-byte page
        set_cfg(2'd0, 6'd4, 6'd3);
        do_read(24'h000300, 3, 4'hF, "R8");
        do_read(24'h000303, 3, 4'hF, "R8");    // hit
        do_read(24'h000304, 3, 4'hF, "R8");    // miss
        // Zero lengths count as one
        set_cfg(2'd0, 6'd0, 6'd0);
        do_read(24'h000400, 0, 4'hF, "R2");
        do_read(24'h000401, 0, 4'hF, "R3");
        // Wait held high has no effect
        set_cfg(2'd2, 6'd9, 6'd3);
        wait_rand = 1'b0;
        mem_wait  = 1'b1;
        do_read(24'h000500, 1, 4'hF, "R10");
        do_read(24'h00050E, 1, 4'h6, "R10");
        wait_rand = 1'b1;

        // Constrained random
        for (int i = 0; i < 400; i++) begin
            int pick = int'($urandom_range(0, 19));
            if (pick == 0) begin
                pulse_other();
            end else if (pick == 1) begin
                set_cfg(2'($urandom_range(0, 3)), 6'($urandom_range(0, 12)),
                        6'($urandom_range(0, 12)));
            end else begin
                logic [ADDR_W-1:0] a;
                a = ADDR_W'(24'h001000 + ($urandom_range(0, 3) * 32)
                            + $urandom_range(0, 31));
                do_read(a, int'($urandom_range(0, 1)), 4'($urandom_range(1, 15)),
                        "R4");
            end
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule